// File: doc/BRIEF.md
# SPI Register Access Controller

This block is a serial-port slave that lets an external controller read and write a bank of 64 byte-wide registers over a four-wire SPI link (mode 0). Every transaction opens with one command byte carrying a direction flag, an auto-advance flag and a 6-bit register index. Any number of data bytes may follow. With auto-advance set, successive bytes walk through consecutive registers and wrap from the top index back to zero. With it clear, every byte hits the same index. At one index (0x20 by default) the storage is a 16-entry first-in first-out queue instead of a plain register, so a fixed-index burst fills or drains it.

All serial logic is clocked by SCK and cleared by the select line, so the bank stays reachable while the system clock is stopped. Each committed write is also reported into the system clock domain as a stream beat (`wr_valid`/`wr_ready`, with index and value). The beat crosses clock domains through a toggle that passes a two-flop synchronizer. The beat and its payload stay stable while `wr_ready` is low. A newer write that arrives before acceptance replaces the pending beat, so only the most recent write is certain to be seen. A consumer that accepts within about seven SCK periods sees every write.

An interrupt input can either drive its own pin or, in the shared mode, be driven onto the MOSI wire while select is inactive.

Top module: `spi_regbank`

## Requirements
- R1: Command byte layout: bit 7 = 1 selects write and 0 selects read, bit 6 = 1 enables address advance, bits 5:0 give the register index. A single write stores its data byte, and a later single read of that index returns it.
- R2: Bits travel MSB first. MOSI is sampled on rising SCK. MISO changes only on falling SCK and carries the read byte starting in the byte after the command. MISO is driven 0 during the command byte. `miso_oe` is 0 whenever `ss_n` is high.
- R3: With bit 6 set, each further data byte of a transaction uses the next index, and index 63 is followed by index 0.
- R4: With bit 6 clear, every data byte of a transaction uses the command's index: writes overwrite the same register and reads return the same value.
- R5: Index 0x20 is a 16-deep queue. A completed write byte pushes, and is dropped when the queue is full. A completed read byte pops in arrival order. A read of an empty queue returns 0x00 and pops nothing.
- R6: Raising `ss_n` at any point aborts the transaction. A partial byte is neither written nor popped, and the next transaction starts again with a command byte.
- R7: After reset all registers read 0x00, the queue is empty and `wr_valid` is 0.
- R8: With `irq_on_mosi` = 0, `irq_pin` follows `irq` and `mosi_oe` is 0. With `irq_on_mosi` = 1, `irq_pin` is 0, `mosi_oe` equals `ss_n`, and `mosi_drv` carries `irq` while `ss_n` is high.
- R9: Every committed write byte, including a dropped queue push, raises one `wr_valid` beat carrying its index and value. Reads raise none. The beat holds while `wr_ready` is low, and a newer write replaces a beat not yet accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the write-report stream |
| rst_n | input | 1 | Active-low asynchronous reset of both domains |
| sck | input | 1 | Serial clock, idles low |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from controller |
| miso | output | 1 | Serial data to controller |
| miso_oe | output | 1 | Drive enable for MISO |
| irq | input | 1 | Interrupt request from the system |
| irq_on_mosi | input | 1 | 1 routes the interrupt onto the MOSI wire |
| irq_pin | output | 1 | Dedicated interrupt output |
| mosi_drv | output | 1 | Value to drive onto the MOSI wire |
| mosi_oe | output | 1 | Drive enable for the MOSI wire |
| wr_valid | output | 1 | A write report is pending |
| wr_ready | input | 1 | Consumer accepts the pending report |
| wr_addr | output | 6 | Register index of the report |
| wr_data | output | 8 | Value written |

## Verification
Two system-side events can land in the same clock cycle: a consumer accepting a pending write report and the arrival of the next report from the serial side. The bench holds `wr_ready` low across a two-byte advancing burst, then releases it at a delay swept over 41 clock steps around the second commit. Some of these releases coincide with the synchronized arrival. Each run passes only if the last accepted beat is the second write. If two beats were accepted, the first must be the first write, and no beat may be accepted twice.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spireg_front.sv
module spireg_front
  import spireg_pkg::*;
(
  input  logic              sck,
  input  logic              ss_n,
  input  logic              rst_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic              rd_done,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              xfer_rst;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] shreg;
  logic              have_cmd;
  cmd_t              cmd;
  logic [DATA_W-1:0] txreg;
  logic              byte_done;

  assign xfer_rst  = ss_n | ~rst_n;
  assign byte_done = (bit_cnt == CNT_W'(DATA_W - 1));
  assign wr_data   = {shreg, mosi};
  assign wr_en     = byte_done & have_cmd & cmd.wr;
  assign rd_done   = byte_done & have_cmd & ~cmd.wr;
  assign cur_addr  = cmd.addr;
  assign miso      = txreg[DATA_W-1];

  // receive side: rising edge
  always_ff @(posedge sck or posedge xfer_rst) begin
    if (xfer_rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      have_cmd <= 1'b0;
      cmd      <= '0;
    end else begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      shreg   <= {shreg[DATA_W-3:0], mosi};
      if (byte_done) begin
        if (!have_cmd) begin
          have_cmd <= 1'b1;
          cmd      <= cmd_t'({shreg, mosi});
        end else if (cmd.inc) begin
          cmd.addr <= cmd.addr + ADDR_W'(1);
        end
      end
    end
  end

  // transmit side: falling edge, loads at each byte boundary of a read
  always_ff @(negedge sck or posedge xfer_rst) begin
    if (xfer_rst)
      txreg <= '0;
    else if (bit_cnt == '0 && have_cmd && !cmd.wr)
      txreg <= rd_data;
    else
      txreg <= {txreg[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spireg_store.sv
module spireg_store
  import spireg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIFO_ADDR  = 6'h20,
  parameter int                FIFO_DEPTH = 16
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [DATA_W-1:0] regs     [NREG];
  logic [DATA_W-1:0] fifo_mem [FIFO_DEPTH];
  logic [PTR_W:0]    wr_ptr, rd_ptr, used;
  logic              hit, full, empty, push, pop;

  assign hit   = (addr == FIFO_ADDR);
  assign used  = wr_ptr - rd_ptr;
  assign full  = (used == (PTR_W+1)'(FIFO_DEPTH));
  assign empty = (used == '0);
  assign push  = wr_en & hit & ~full;
  assign pop   = rd_done & hit & ~empty;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && !hit) begin
      regs[addr] <= wr_data;
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + (PTR_W+1)'(1);
      if (pop)  rd_ptr <= rd_ptr + (PTR_W+1)'(1);
    end
  end

  always_ff @(posedge sck) begin
    if (push) fifo_mem[wr_ptr[PTR_W-1:0]] <= wr_data;
  end

  always_comb begin
    if (!hit)       rd_data = regs[addr];
    else if (empty) rd_data = '0;
    else            rd_data = fifo_mem[rd_ptr[PTR_W-1:0]];
  end
endmodule

// File: rtl/spireg_wr_sync.sv
module spireg_wr_sync
  import spireg_pkg::*;
(
  input  logic              sck,
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic              tog;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic [2:0]        sync;
  logic              arrive;

  // serial side: hold the payload and flip the request toggle
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      tog    <= 1'b0;
      h_addr <= '0;
      h_data <= '0;
    end else if (wr_en) begin
      tog    <= ~tog;
      h_addr <= addr;
      h_data <= data;
    end
  end

  // system side: two-flop synchronizer plus edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], tog};
  end

  assign arrive = sync[2] ^ sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else if (arrive) begin
      valid    <= 1'b1;
      out_addr <= h_addr;
      out_data <= h_data;
    end else if (ready) begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spireg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIFO_ADDR  = 6'h20,
  parameter int                FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              irq,
  input  logic              irq_on_mosi,
  output logic              irq_pin,
  output logic              mosi_drv,
  output logic              mosi_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_data, bus_wdata;
  logic              bus_wr, bus_rd;

  spireg_front u_front (
    .sck(sck), .ss_n(ss_n), .rst_n(rst_n), .mosi(mosi),
    .rd_data(rd_data), .cur_addr(cur_addr), .wr_en(bus_wr),
    .rd_done(bus_rd), .wr_data(bus_wdata), .miso(miso)
  );

  spireg_store #(.FIFO_ADDR(FIFO_ADDR), .FIFO_DEPTH(FIFO_DEPTH)) u_store (
    .sck(sck), .rst_n(rst_n), .wr_en(bus_wr), .rd_done(bus_rd),
    .addr(cur_addr), .wr_data(bus_wdata), .rd_data(rd_data)
  );

  spireg_wr_sync u_sync (
    .sck(sck), .clk(clk), .rst_n(rst_n), .wr_en(bus_wr),
    .addr(cur_addr), .data(bus_wdata), .ready(wr_ready),
    .valid(wr_valid), .out_addr(wr_addr), .out_data(wr_data)
  );

  assign miso_oe  = ~ss_n;
  assign irq_pin  = irq_on_mosi ? 1'b0 : irq;
  assign mosi_oe  = irq_on_mosi & ss_n;
  assign mosi_drv = irq_on_mosi & ss_n & irq;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ss_n,
  input logic miso,
  input logic miso_oe,
  input logic irq_on_mosi,
  input logic irq_pin,
  input logic mosi_oe,
  input logic wr_valid,
  input logic wr_ready
);
  assert_miso_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !miso_oe);

  assert_miso_steady_R2: assert property (@(posedge clk) disable iff (!rst_n || ss_n)
    (sck && $past(sck) && !$past(ss_n)) |-> $stable(miso));

  assert_mosi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> !mosi_oe);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_on_mosi |-> !irq_pin);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R7: assert (!wr_valid);
  end
endmodule

bind spi_regbank spi_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .miso(miso),
  .miso_oe(miso_oe), .irq_on_mosi(irq_on_mosi), .irq_pin(irq_pin),
  .mosi_oe(mosi_oe), .wr_valid(wr_valid), .wr_ready(wr_ready)
);

// File: tb/spi_regbank_test.sv
`timescale 1ns/1ps
module spi_regbank_test;
  logic clk = 0, rst_n = 0, sck = 0, ss_n = 1, mosi = 0;
  logic irq = 0, irq_on_mosi = 0, wr_ready = 1;
  logic miso, miso_oe, irq_pin, mosi_drv, mosi_oe, wr_valid;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  spi_regbank uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .irq(irq), .irq_on_mosi(irq_on_mosi),
    .irq_pin(irq_pin), .mosi_drv(mosi_drv), .mosi_oe(mosi_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, sck_edges = 0;
  logic [7:0]  model [64];
  logic [7:0]  txb [64];
  logic [7:0]  rxb [64];
  logic [13:0] evq [$];
  logic        cmd_miso_seen = 0, oe_low_seen = 0;
  logic [7:0]  rv;

  always @(negedge clk) if (wr_valid && wr_ready) evq.push_back({wr_addr, wr_data});

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  // MSB-first frame of nbytes whole bytes plus extra_bits, then SS high
  task automatic xfer(input int nbytes, input int extra_bits);
    ss_n = 0;
    #20;
    for (int i = 0; i < nbytes * 8 + extra_bits; i++) begin
      mosi = txb[i/8][7 - (i%8)];
      #10;
      rxb[i/8][7 - (i%8)] = miso;
      if (i < 8 && miso) cmd_miso_seen = 1;
      if (!miso_oe) oe_low_seen = 1;
      #10;
      sck = 1;
      sck_edges++;
      #20;
      sck = 0;
    end
    #20;
    ss_n = 1;
    #40;
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d);
    txb[0] = {2'b10, a};
    txb[1] = d;
    xfer(2, 0);
    if (a != 6'h20) model[a] = d;
  endtask

  task automatic rd1(input logic [5:0] a, output logic [7:0] d);
    txb[0] = {2'b00, a};
    txb[1] = 8'h00;
    xfer(2, 0);
    d = rxb[1];
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R7: reset state
    check("R7 wr_valid after reset", wr_valid, 0);
    check("R2 miso_oe idle", miso_oe, 0);
    rd1(6'd5, rv);  check("R7 reg5 after reset", rv, 0);
    rd1(6'h20, rv); check("R7 empty queue reads zero", rv, 0);

    // R1/R9: single write to every plain index, then read back
    for (int a = 0; a < 64; a++) begin
      if (a == 32) continue;
      wr1(6'(a), 8'((a * 37 + 11) % 256));
      settle();
      check("R9 one beat per write", evq.size(), 1);
      if (evq.size() > 0) check("R9 beat payload", evq[0], {6'(a), 8'((a * 37 + 11) % 256)});
      evq.delete();
    end
    for (int a = 0; a < 64; a++) begin
      if (a == 32) continue;
      rd1(6'(a), rv);
      check("R1 single read", rv, (a * 37 + 11) % 256);
    end
    settle();
    check("R9 reads raise no beat", evq.size(), 0);
    check("R2 miso low in command byte", cmd_miso_seen, 0);
    check("R2 miso_oe high while selected", oe_low_seen, 0);

    // R3: advancing burst across the 63 -> 0 wrap
    txb[0] = {2'b11, 6'd60};
    for (int k = 0; k < 8; k++) begin
      txb[1 + k] = 8'hA0 + 8'(k);
      model[(60 + k) % 64] = 8'hA0 + 8'(k);
    end
    xfer(9, 0);
    settle();
    check("R3 beats in burst", evq.size(), 8);
    for (int k = 0; k < 8 && k < evq.size(); k++)
      check("R3 burst index order", evq[k], {6'((60 + k) % 64), 8'hA0 + 8'(k)});
    evq.delete();
    txb[0] = {2'b01, 6'd60};
    xfer(9, 0);
    for (int k = 0; k < 8; k++) check("R3 burst read", rxb[1 + k], model[(60 + k) % 64]);

    // R4: fixed-index burst on a plain register
    txb[0] = {2'b10, 6'd7};
    txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    xfer(4, 0);
    model[7] = 8'h33;
    settle();
    check("R4 beats", evq.size(), 3);
    evq.delete();
    txb[0] = {2'b00, 6'd7};
    xfer(4, 0);
    for (int k = 1; k < 4; k++) check("R4 repeated read", rxb[k], 8'h33);
    rd1(6'd8, rv); check("R4 neighbour untouched", rv, model[8]);

    // R5: queue overfill, drain, empty read
    txb[0] = {2'b10, 6'h20};
    for (int k = 0; k < 18; k++) txb[1 + k] = 8'h50 + 8'(k);
    xfer(19, 0);
    settle();
    check("R9 dropped pushes still reported", evq.size(), 18);
    evq.delete();
    txb[0] = {2'b00, 6'h20};
    xfer(18, 0);
    for (int k = 0; k < 16; k++) check("R5 pop order", rxb[1 + k], 8'h50 + 8'(k));
    check("R5 read past empty", rxb[17], 0);
    rd1(6'h20, rv); check("R5 empty read", rv, 0);
    wr1(6'h20, 8'hC1); wr1(6'h20, 8'hC2); wr1(6'h20, 8'hC3);
    rd1(6'h20, rv); check("R5 single pop 1", rv, 8'hC1);
    rd1(6'h20, rv); check("R5 single pop 2", rv, 8'hC2);
    txb[0] = {2'b01, 6'h1F};
    xfer(3, 0);
    check("R3 burst before queue", rxb[1], model[6'h1F]);
    check("R5 burst into queue", rxb[2], 8'hC3);
    rd1(6'h20, rv); check("R5 empty after drain", rv, 0);
    settle();
    evq.delete();

    // R6: aborts
    txb[0] = {2'b10, 6'd9};
    txb[1] = 8'hFF;
    xfer(1, 5);
    settle();
    check("R6 partial write no beat", evq.size(), 0);
    rd1(6'd9, rv); check("R6 partial write not stored", rv, model[9]);
    txb[0] = {2'b10, 6'd9};
    xfer(0, 4);
    wr1(6'd9, 8'h5A);
    rd1(6'd9, rv); check("R6 fresh command after abort", rv, 8'h5A);
    wr1(6'h20, 8'h77);
    txb[0] = {2'b00, 6'h20};
    xfer(1, 4);
    rd1(6'h20, rv); check("R6 partial read no pop", rv, 8'h77);
    settle();
    evq.delete();

    // R8: interrupt routing
    irq_on_mosi = 0; irq = 1; #10;
    check("R8 dedicated pin high", irq_pin, 1);
    check("R8 mosi released", mosi_oe, 0);
    irq = 0; #10;
    check("R8 dedicated pin low", irq_pin, 0);
    irq_on_mosi = 1; irq = 1; #10;
    check("R8 pin quiet when shared", irq_pin, 0);
    check("R8 mosi driven when idle", mosi_oe, 1);
    check("R8 mosi carries irq", mosi_drv, 1);
    ss_n = 0; #10;
    check("R8 mosi released when selected", mosi_oe, 0);
    ss_n = 1; irq = 0; #10;
    check("R8 mosi carries irq low", mosi_drv, 0);
    wr1(6'd12, 8'h3D);
    rd1(6'd12, rv); check("R8 access with shared mode", rv, 8'h3D);
    irq_on_mosi = 0;
    settle();
    evq.delete();

    // R9: back-pressure
    @(posedge clk); #1 wr_ready = 0;
    wr1(6'd3, 8'h3C);
    settle();
    check("R9 valid held", wr_valid, 1);
    check("R9 addr held", wr_addr, 3);
    check("R9 data held", wr_data, 8'h3C);
    repeat (20) @(posedge clk); #1;
    check("R9 still held", wr_valid, 1);
    wr_ready = 1;
    settle();
    check("R9 accepted once", evq.size(), 1);
    if (evq.size() > 0) check("R9 accepted payload", evq[0], {6'd3, 8'h3C});
    check("R9 valid dropped", wr_valid, 0);
    evq.delete();

    // R9: acceptance coinciding with a new arrival, swept
    for (int d = 0; d <= 40; d++) begin
      @(posedge clk); #1 wr_ready = 0;
      txb[0] = {2'b11, 6'd10};
      txb[1] = 8'(d);
      txb[2] = 8'(d + 100);
      sck_edges = 0;
      fork
        xfer(3, 0);
        begin
          wait (sck_edges == 22);
          repeat (d) @(posedge clk);
          #1 wr_ready = 1;
        end
      join
      model[10] = 8'(d);
      model[11] = 8'(d + 100);
      settle();
      check("R9 sweep beat count bound", int'(evq.size() >= 1 && evq.size() <= 2), 1);
      if (evq.size() >= 1)
        check("R9 sweep newest delivered", evq[evq.size() - 1], {6'd11, 8'(d + 100)});
      if (evq.size() == 2)
        check("R9 sweep older first", evq[0], {6'd10, 8'(d)});
      evq.delete();
    end

    summary();
    $finish;
  end
endmodule